// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block translates logical general-register numbers into physical indices for a 128-entry, 64-bit register file. The file is split in two. The low 32 registers form a global region whose mapping never changes. The upper 96 registers form a stacked region that is treated as a ring. Each procedure owns a window, or frame, inside that ring, and the window starts at a movable base. Every lookup port turns a logical number into a physical number combinationally, so a translation is ready in the same cycle as its request.

A frame marker holds the current base, the frame size and the count of locals. A call command slides the base past the caller's locals, so the caller's outgoing registers become the callee's first registers and no data is copied. A return command restores the saved marker. An allocate command resizes the current frame without moving it. An eight-deep history of saved markers backs call and return. An overflow or underflow flag pulses when a command cannot be honoured, and the state stays unchanged in that case. Spilling frames to memory is the job of a separate engine.

Top module: `rfr_frame_renamer`

## Requirements
- R1: After reset the base, frame size, locals count and history depth are all 0, and both flags are low.
- R2: A logical index below 32 maps to the physical index of the same value and is never flagged illegal.
- R3: A logical index L of 32 or more maps, combinationally in the same cycle, to 32 + ((L − 32 + base) mod 96).
- R4: A logical index L of 32 or more with L − 32 greater than or equal to the frame size raises that port's illegal flag. Indices inside the frame leave the flag low.
- R5: An accepted call saves the current marker on the history. From the next cycle the base is (base + locals) mod 96, the frame size is the old size minus the old locals, the locals count is 0, and the depth has gone up by one.
- R6: An accepted return removes the newest saved marker and restores its base, size and locals exactly from the next cycle. The depth goes down by one.
- R7: A call issued while the history already holds 8 markers raises the overflow flag in the next cycle and leaves the marker and depth unchanged.
- R8: A return issued with an empty history raises the underflow flag in the next cycle and leaves the marker and depth unchanged.
- R9: An allocate replaces the frame size and locals count from the next cycle and keeps the base. It is rejected with the overflow flag, and the state left untouched, if the requested size exceeds 96 or the locals count exceeds the requested size.
- R10: The command code is 0 for idle, 1 for call, 2 for return and 3 for allocate. Idle changes nothing. Each flag is high only in the cycle after a failed command and is low again after any command that succeeds or after an idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 idle, 1 call, 2 return, 3 allocate |
| cmd_sof | input | 7 | Requested frame size for allocate |
| cmd_sol | input | 7 | Requested locals count for allocate |
| xl_lidx | input | NUM_PORTS*7 | Logical indices, port p in bits [7p+6:7p] |
| xl_pidx | output | NUM_PORTS*7 | Physical indices, same packing |
| xl_illegal | output | NUM_PORTS | Per-port flag for an index beyond the frame |
| cur_base | output | 7 | Current frame base inside the stacked ring |
| cur_sof | output | 7 | Current frame size |
| cur_sol | output | 7 | Current locals count |
| hist_depth | output | 4 | Number of saved markers |
| ovf_flag | output | 1 | Overflow pulse |
| unf_flag | output | 1 | Underflow pulse |

## Verification
The bench targets ring wraparound by moving the base to 90 and then reading registers whose offset passes the end of the ring. A design that takes the modulus wrongly would hand out indices in the global region or above 127. It fills the history to exactly eight entries and then issues a ninth call, and it empties the history and then issues one more return. An off-by-one in the depth test would either corrupt a saved marker or restore garbage. Allocate requests of size 97 and of locals larger than size must be refused with the marker intact. A long random run of mixed commands checks that every restored marker matches the one saved, and that the flags fall back low one cycle after a failure.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    localparam int unsigned IDX_W = 7;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CALL  = 2'd1,
        OP_RET   = 2'd2,
        OP_ALLOC = 2'd3
    } frame_op_e;

    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] sof;
        logic [IDX_W-1:0] sol;
    } frame_mark_t;

endpackage

// File: rtl/rfr_hist_stack.sv
module rfr_hist_stack
    import rfr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  frame_mark_t      din,
    output frame_mark_t      dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        frame_mark_t [DEPTH-1:0] slot;
        logic [CNT_W-1:0]        cnt;
    } hs_state_t;

    hs_state_t st_d, st_q;
    logic [CNT_W-1:0] top_idx;

    assign top_idx = st_q.cnt - 1'b1;
    assign count   = st_q.cnt;
    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign dout    = empty ? '0 : st_q.slot[top_idx];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.slot[st_q.cnt] = din;
            st_d.cnt            = st_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rfr_xlate.sv
module rfr_xlate
    import rfr_pkg::*;
#(
    parameter int unsigned NUM_PHYS   = 128,
    parameter int unsigned NUM_GLOBAL = 32,
    localparam int unsigned STACKED   = NUM_PHYS - NUM_GLOBAL
) (
    input  logic [IDX_W-1:0] lidx,
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] sof,
    output logic [IDX_W-1:0] pidx,
    output logic             illegal
);

    localparam logic [IDX_W:0] GLB_C = (IDX_W+1)'(NUM_GLOBAL);
    localparam logic [IDX_W:0] STK_C = (IDX_W+1)'(STACKED);

    logic [IDX_W:0] off;
    logic [IDX_W:0] sum;
    logic [IDX_W:0] wrapped;
    logic [IDX_W:0] phys;
    logic           is_global;

    always_comb begin
        is_global = ({1'b0, lidx} < GLB_C);
        off       = {1'b0, lidx} - GLB_C;
        sum       = off + {1'b0, base};
        wrapped   = (sum >= STK_C) ? (sum - STK_C) : sum;
        phys      = is_global ? {1'b0, lidx} : (wrapped + GLB_C);
        pidx      = phys[IDX_W-1:0];
        illegal   = !is_global && (off >= {1'b0, sof});
    end

endmodule

// File: rtl/rfr_frame_renamer.sv
module rfr_frame_renamer
    import rfr_pkg::*;
#(
    parameter int unsigned NUM_PHYS   = 128,
    parameter int unsigned NUM_GLOBAL = 32,
    parameter int unsigned HIST_DEPTH = 8,
    parameter int unsigned NUM_PORTS  = 3,
    localparam int unsigned CNT_W     = $clog2(HIST_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cmd_op,
    input  logic [IDX_W-1:0]           cmd_sof,
    input  logic [IDX_W-1:0]           cmd_sol,
    input  logic [NUM_PORTS*IDX_W-1:0] xl_lidx,
    output logic [NUM_PORTS*IDX_W-1:0] xl_pidx,
    output logic [NUM_PORTS-1:0]       xl_illegal,
    output logic [IDX_W-1:0]           cur_base,
    output logic [IDX_W-1:0]           cur_sof,
    output logic [IDX_W-1:0]           cur_sol,
    output logic [CNT_W-1:0]           hist_depth,
    output logic                       ovf_flag,
    output logic                       unf_flag
);

    localparam int unsigned STACKED = NUM_PHYS - NUM_GLOBAL;
    localparam logic [IDX_W:0] STK_C = (IDX_W+1)'(STACKED);

    typedef struct packed {
        frame_mark_t cfm;
        logic        ovf;
        logic        unf;
    } rn_state_t;

    rn_state_t   st_d, st_q;
    frame_op_e   op;
    logic        h_push, h_pop, h_full, h_empty;
    frame_mark_t h_top;
    logic [IDX_W:0] base_sum;

    assign op = frame_op_e'(cmd_op);

    rfr_hist_stack #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (h_push),
        .pop   (h_pop),
        .din   (st_q.cfm),
        .dout  (h_top),
        .count (hist_depth),
        .full  (h_full),
        .empty (h_empty)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        h_push   = 1'b0;
        h_pop    = 1'b0;
        base_sum = {1'b0, st_q.cfm.base} + {1'b0, st_q.cfm.sol};
        unique case (op)
            OP_CALL: begin
                if (h_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    h_push        = 1'b1;
                    st_d.cfm.base = (base_sum >= STK_C) ? IDX_W'(base_sum - STK_C)
                                                        : IDX_W'(base_sum);
                    st_d.cfm.sof  = st_q.cfm.sof - st_q.cfm.sol;
                    st_d.cfm.sol  = '0;
                end
            end
            OP_RET: begin
                if (h_empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    h_pop    = 1'b1;
                    st_d.cfm = h_top;
                end
            end
            OP_ALLOC: begin
                if (({1'b0, cmd_sof} > STK_C) || (cmd_sol > cmd_sof)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.cfm.sof = cmd_sof;
                    st_d.cfm.sol = cmd_sol;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            rfr_xlate #(.NUM_PHYS(NUM_PHYS), .NUM_GLOBAL(NUM_GLOBAL)) u_xl (
                .lidx    (xl_lidx[p*IDX_W +: IDX_W]),
                .base    (st_q.cfm.base),
                .sof     (st_q.cfm.sof),
                .pidx    (xl_pidx[p*IDX_W +: IDX_W]),
                .illegal (xl_illegal[p])
            );
        end
    endgenerate

    assign cur_base = st_q.cfm.base;
    assign cur_sof  = st_q.cfm.sof;
    assign cur_sol  = st_q.cfm.sol;
    assign ovf_flag = st_q.ovf;
    assign unf_flag = st_q.unf;

endmodule

// File: rtl/rfr_frame_renamer_chk.sv
module rfr_frame_renamer_chk
    import rfr_pkg::*;
#(
    parameter int unsigned NUM_PHYS   = 128,
    parameter int unsigned NUM_GLOBAL = 32,
    parameter int unsigned HIST_DEPTH = 8,
    parameter int unsigned NUM_PORTS  = 3,
    localparam int unsigned CNT_W     = $clog2(HIST_DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 cmd_op,
    input logic [NUM_PORTS*IDX_W-1:0] xl_lidx,
    input logic [NUM_PORTS*IDX_W-1:0] xl_pidx,
    input logic [NUM_PORTS-1:0]       xl_illegal,
    input logic [IDX_W-1:0]           cur_base,
    input logic [IDX_W-1:0]           cur_sof,
    input logic [IDX_W-1:0]           cur_sol,
    input logic [CNT_W-1:0]           hist_depth,
    input logic                       ovf_flag,
    input logic                       unf_flag
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(HIST_DEPTH);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            p_globals_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (xl_lidx[p*IDX_W +: IDX_W] < IDX_W'(NUM_GLOBAL)) |->
                ((xl_pidx[p*IDX_W +: IDX_W] == xl_lidx[p*IDX_W +: IDX_W]) && !xl_illegal[p]));
            p_stacked_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (xl_lidx[p*IDX_W +: IDX_W] >= IDX_W'(NUM_GLOBAL)) |->
                (xl_pidx[p*IDX_W +: IDX_W] >= IDX_W'(NUM_GLOBAL)));
        end
    endgenerate

    p_call_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd1 && hist_depth != FULL_C) |=>
        (hist_depth == $past(hist_depth) + 1'b1 && cur_sol == '0 && !ovf_flag));

    p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hist_depth <= FULL_C);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd1 && hist_depth == FULL_C) |=>
        (ovf_flag && $stable(cur_base) && $stable(cur_sof) && $stable(hist_depth)));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd2 && hist_depth == '0) |=>
        (unf_flag && $stable(cur_base) && $stable(cur_sof) && hist_depth == '0));

    p_alloc_keeps_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd3) |=> ($stable(cur_base) && $stable(hist_depth)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd0) |=> (!ovf_flag && !unf_flag && $stable(cur_base) && $stable(cur_sof)));

endmodule

bind rfr_frame_renamer rfr_frame_renamer_chk #(
    .NUM_PHYS   (NUM_PHYS),
    .NUM_GLOBAL (NUM_GLOBAL),
    .HIST_DEPTH (HIST_DEPTH),
    .NUM_PORTS  (NUM_PORTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .xl_lidx    (xl_lidx),
    .xl_pidx    (xl_pidx),
    .xl_illegal (xl_illegal),
    .cur_base   (cur_base),
    .cur_sof    (cur_sof),
    .cur_sol    (cur_sol),
    .hist_depth (hist_depth),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/sim_rfr_frame_renamer.sv
`timescale 1ns/1ps
module sim_rfr_frame_renamer;

    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cmd_op;
    logic [6:0]    cmd_sof, cmd_sol;
    logic [NP*7-1:0] xl_lidx, xl_pidx;
    logic [NP-1:0] xl_illegal;
    logic [6:0]    cur_base, cur_sof, cur_sol;
    logic [3:0]    hist_depth;
    logic          ovf_flag, unf_flag;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    int m_base, m_sof, m_sol;
    bit m_ovf, m_unf;
    int hist[$];

    always #4 clk = ~clk;

    rfr_frame_renamer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_sof(cmd_sof), .cmd_sol(cmd_sol),
        .xl_lidx(xl_lidx), .xl_pidx(xl_pidx), .xl_illegal(xl_illegal),
        .cur_base(cur_base), .cur_sof(cur_sof), .cur_sol(cur_sol),
        .hist_depth(hist_depth), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_lookups();
        for (int p = 0; p < NP; p++) begin
            int l, ep, ei;
            l  = int'(xl_lidx[p*7 +: 7]);
            ep = (l < 32) ? l : 32 + ((l - 32 + m_base) % 96);
            ei = (l >= 32 && (l - 32) >= m_sof) ? 1 : 0;
            chk((l < 32) ? "R2" : "R3", $sformatf("pidx port%0d lidx=%0d", p, l),
                int'(xl_pidx[p*7 +: 7]), ep);
            chk((l < 32) ? "R2" : "R4", $sformatf("illegal port%0d lidx=%0d", p, l),
                int'(xl_illegal[p]), ei);
        end
    endtask

    task automatic check_state(string req);
        chk(req, "base",  int'(cur_base),   m_base);
        chk(req, "sof",   int'(cur_sof),    m_sof);
        chk(req, "sol",   int'(cur_sol),    m_sol);
        chk(req, "depth", int'(hist_depth), hist.size());
        chk(req, "ovf",   int'(ovf_flag),   int'(m_ovf));
        chk(req, "unf",   int'(unf_flag),   int'(m_unf));
    endtask

    task automatic step(int op, int sof, int sol, int l0, int l1, int l2);
        string req;
        @(negedge clk);
        cmd_op  = 2'(op);
        cmd_sof = 7'(sof);
        cmd_sol = 7'(sol);
        xl_lidx = {7'(l2), 7'(l1), 7'(l0)};
        #1;
        check_lookups();
        @(posedge clk);
        #1;
        m_ovf = 0;
        m_unf = 0;
        req   = "R10";
        case (op)
            1: if (hist.size() == 8) begin
                   m_ovf = 1; req = "R7";
               end else begin
                   hist.push_back(m_base * 65536 + m_sof * 256 + m_sol);
                   m_base = (m_base + m_sol) % 96;
                   m_sof  = m_sof - m_sol;
                   m_sol  = 0;
                   req    = "R5";
               end
            2: if (hist.size() == 0) begin
                   m_unf = 1; req = "R8";
               end else begin
                   int v;
                   v      = hist.pop_back();
                   m_base = v / 65536;
                   m_sof  = (v / 256) % 256;
                   m_sol  = v % 256;
                   req    = "R6";
               end
            3: begin
                   req = "R9";
                   if (sof > 96 || sol > sof) m_ovf = 1;
                   else begin m_sof = sof; m_sol = sol; end
               end
            default: ;
        endcase
        check_state(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        m_base = 0; m_sof = 0; m_sol = 0; m_ovf = 0; m_unf = 0;
        rst_n   = 1'b0;
        cmd_op  = 2'd0;
        cmd_sof = '0;
        cmd_sol = '0;
        xl_lidx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_state("R1");

        // R2 and R4 with an empty frame
        step(0, 0, 0, 0, 31, 32);
        // R9: allocate, then probe the frame edge (R3, R4)
        step(3, 20, 8, 32, 51, 52);
        step(0, 0, 0, 32, 51, 52);
        // R5: call moves base by locals
        step(1, 0, 0, 5, 32, 40);
        step(0, 0, 0, 32, 43, 44);
        // fill history to 8 (R5), then ninth call overflows (R7)
        for (int i = 0; i < 7; i++) begin
            step(3, 30, 10, 32, 60, 61);
            step(1, 0, 0, 32, 50, 127);
        end
        step(1, 0, 0, 32, 33, 34);
        // R10: flag clears after idle
        step(0, 0, 0, 32, 33, 34);
        // unwind (R6), then one extra return (R8)
        for (int i = 0; i < 8; i++) step(2, 0, 0, 32, 45, 100);
        step(2, 0, 0, 32, 33, 34);
        step(0, 0, 0, 1, 2, 3);
        // R9 rejections
        step(3, 97, 0, 32, 33, 34);
        step(3, 127, 5, 32, 33, 34);
        step(3, 10, 11, 32, 33, 34);
        // wraparound: base 90, offsets past ring end (R3)
        step(3, 96, 90, 32, 127, 100);
        step(1, 0, 0, 32, 37, 38);
        step(3, 40, 0, 42, 127, 71);
        step(0, 0, 0, 38, 37, 71);
        step(2, 0, 0, 32, 127, 100);

        // mixed random run
        for (int i = 0; i < 600; i++) begin
            int op, sf, sl;
            op = $urandom_range(0, 3);
            sf = $urandom_range(0, 100);
            sl = $urandom_range(0, sf + 2);
            if (sl > 127) sl = 127;
            step(op, sf, sl, $urandom_range(0, 127), $urandom_range(0, 127),
                 $urandom_range(0, 127));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule